// File: doc/BRIEF.md
# Fixed-Point Four-Quadrant Arctangent Unit

This unit takes a signed Cartesian pair, each coordinate a 16-bit value with one integer bit and fifteen fraction bits, and returns the angle of that vector. The angle is expressed in half-turns: a full circle spans minus one to plus one, so the number 0.5 means a quarter turn counter-clockwise from the positive x axis. The full-precision angle is 18 bits wide with two integer bits and sixteen fraction bits. Two integer bits are needed because an angle of exactly +1.0 can occur. A 16-bit copy is also produced, with one integer bit and fifteen fraction bits. It is formed by dropping the top bit and the lowest fraction bit, so +1.0 wraps to -1.0, and both extremes of the circle share a single code.

The core is an iterative vectoring rotator that performs one micro-rotation per clock. Before the iterations, any vector with a negative x coordinate is turned through half a turn. Operands enter through a valid/ready handshake. The unit holds one job at a time: `in_ready` is high only while the unit is idle, and an operand is taken on a clock edge where `in_valid` and `in_ready` are both high. The output side has no back-pressure. `out_valid` is a single-cycle pulse, and the result pins hold their value until the next result arrives. A caller that cannot consume the result in the pulse cycle must capture it from the held pins before its next accepted request completes.

Top module: `pi_atan2_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and both angle outputs are 0.
- R2: `in_ready` is 1 exactly when no job is in flight. It drops on the cycle after an accepting edge and rises again in the cycle where `out_valid` pulses. While `in_ready` is 0, `in_valid` and the operand pins are ignored.
- R3: `out_valid` rises exactly 18 clock edges after the accepting edge and stays high for one cycle only. `in_ready` is 1 during that cycle.
- R4: For an operand whose larger coordinate magnitude is at least 0.5, `out_angle_wide` is a signed Q2.16 value that lies within 16 LSBs of atan2(y, x)/pi × 65536. Values of +1.0 and -1.0 are treated as the same angle.
- R5: `out_angle` equals bits 16 down to 1 of `out_angle_wide`. It is the wrapped Q1.15 half-turn angle, so +1.0 appears as 0x8000, which is -1.0.
- R6: An operand with x = 0 and y = 0 yields exactly 0 on both outputs.
- R7: An operand with x < 0 and y = 0 yields a half-turn: `out_angle` is within 8 LSBs of 0x8000, counting around the wrap.
- R8: Axis operands land on their quadrant boundaries. When x > 0 and y = 0 the result is near 0. When x = 0 and y > 0 the result is near +0.5 (0x4000 in `out_angle`). When x = 0 and y < 0 the result is near -0.5.
- R9: Between two `out_valid` pulses, `out_angle_wide` and `out_angle` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle; operand taken when both are high |
| in_x | input | 16 | x coordinate, signed Q1.15 |
| in_y | input | 16 | y coordinate, signed Q1.15 |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_angle_wide | output | 18 | Angle in half-turns, signed Q2.16 |
| out_angle | output | 16 | Angle in half-turns, signed Q1.15, wrapped |

## Verification
The assertions assume that the caller never relies on back-pressure at the output. They also assume that every operand is a sensible vector, so that the result always lies within a small margin of the ±1.0 half-turn range. The stimulus meets the accuracy condition by keeping the larger coordinate magnitude at or above 0.5, and it includes the exact extremes -1.0 and just under +1.0 on both axes. The stimulus also holds `in_valid` high with decoy operands while a job is running, and it streams jobs back to back. Together these check that only operands presented while the unit is idle are taken.

// File: rtl/pi_atan2_pkg.sv
package pi_atan2_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_RUN,
    ST_FINISH
  } atan2_state_e;

  // arctan(2^-k) / pi, scaled by 2^16 and rounded
  function automatic int atan_step(input int k);
    case (k)
      0:       atan_step = 16384;
      1:       atan_step = 9672;
      2:       atan_step = 5110;
      3:       atan_step = 2594;
      4:       atan_step = 1302;
      5:       atan_step = 652;
      6:       atan_step = 326;
      7:       atan_step = 163;
      8:       atan_step = 81;
      9:       atan_step = 41;
      10:      atan_step = 20;
      11:      atan_step = 10;
      12:      atan_step = 5;
      13:      atan_step = 3;
      14:      atan_step = 1;
      15:      atan_step = 1;
      default: atan_step = 20861 >>> k;
    endcase
  endfunction

endpackage

// File: rtl/pi_atan2_fold.sv
module pi_atan2_fold #(
  parameter int IN_W  = 16,
  parameter int GUARD = 2,
  parameter int DW    = IN_W + GUARD + 2,
  parameter int ANG_W = 18
) (
  input  logic [IN_W-1:0]         raw_x,
  input  logic [IN_W-1:0]         raw_y,
  output logic signed [DW-1:0]    fx,
  output logic signed [DW-1:0]    fy,
  output logic signed [ANG_W-1:0] fz,
  output logic                    is_origin
);
  localparam int HEAD = DW - IN_W - GUARD;
  localparam logic signed [ANG_W-1:0] HALF_TURN = {2'b01, {(ANG_W-2){1'b0}}};

  logic signed [DW-1:0] ex, ey;

  generate
    if (GUARD > 0) begin : g_guard
      assign ex = {{HEAD{raw_x[IN_W-1]}}, raw_x, {GUARD{1'b0}}};
      assign ey = {{HEAD{raw_y[IN_W-1]}}, raw_y, {GUARD{1'b0}}};
    end else begin : g_noguard
      assign ex = {{HEAD{raw_x[IN_W-1]}}, raw_x};
      assign ey = {{HEAD{raw_y[IN_W-1]}}, raw_y};
    end
  endgenerate

  always_comb begin
    is_origin = (raw_x == '0) && (raw_y == '0);
    if (raw_x[IN_W-1]) begin
      // left half-plane: turn through half a circle first
      fx = -ex;
      fy = -ey;
      fz = raw_y[IN_W-1] ? -HALF_TURN : HALF_TURN;
    end else begin
      fx = ex;
      fy = ey;
      fz = '0;
    end
  end
endmodule

// File: rtl/pi_atan2_microrot.sv
module pi_atan2_microrot #(
  parameter int DW    = 20,
  parameter int ANG_W = 18,
  parameter int SH_W  = 4
) (
  input  logic signed [DW-1:0]    cx,
  input  logic signed [DW-1:0]    cy,
  input  logic signed [ANG_W-1:0] cz,
  input  logic [SH_W-1:0]         shamt,
  input  logic signed [ANG_W-1:0] step_ang,
  output logic signed [DW-1:0]    nx,
  output logic signed [DW-1:0]    ny,
  output logic signed [ANG_W-1:0] nz
);
  logic signed [DW-1:0] xs, ys;

  assign xs = cx >>> shamt;
  assign ys = cy >>> shamt;

  always_comb begin
    if (!cy[DW-1]) begin
      nx = cx + ys;
      ny = cy - xs;
      nz = cz + step_ang;
    end else begin
      nx = cx - ys;
      ny = cy + xs;
      nz = cz - step_ang;
    end
  end
endmodule

// File: rtl/pi_atan2_unit.sv
module pi_atan2_unit #(
  parameter int IN_W  = 16,
  parameter int GUARD = 2,
  parameter int ITER  = 16,
  parameter int ANG_W = 18,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_x,
  input  logic [IN_W-1:0]  in_y,
  output logic             out_valid,
  output logic [ANG_W-1:0] out_angle_wide,
  output logic [OUT_W-1:0] out_angle
);
  import pi_atan2_pkg::*;

  localparam int DW   = IN_W + GUARD + 2;
  localparam int SH_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [SH_W-1:0] LAST_STEP = SH_W'(ITER - 1);

  atan2_state_e st_q;
  logic [SH_W-1:0]         iter_q;
  logic [IN_W-1:0]         cap_x, cap_y;
  logic signed [DW-1:0]    x_q, y_q;
  logic signed [ANG_W-1:0] z_q;
  logic                    origin_q;
  logic [ANG_W-1:0]        res_q;
  logic                    vld_q;

  logic signed [DW-1:0]    fold_x, fold_y, rot_x, rot_y;
  logic signed [ANG_W-1:0] fold_z, rot_z, step_ang;
  logic                    fold_origin;

  pi_atan2_fold #(.IN_W(IN_W), .GUARD(GUARD), .DW(DW), .ANG_W(ANG_W)) u_fold (
    .raw_x(cap_x), .raw_y(cap_y),
    .fx(fold_x), .fy(fold_y), .fz(fold_z), .is_origin(fold_origin)
  );

  assign step_ang = ANG_W'(atan_step(int'(iter_q)));

  pi_atan2_microrot #(.DW(DW), .ANG_W(ANG_W), .SH_W(SH_W)) u_rot (
    .cx(x_q), .cy(y_q), .cz(z_q), .shamt(iter_q), .step_ang(step_ang),
    .nx(rot_x), .ny(rot_y), .nz(rot_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      iter_q   <= '0;
      cap_x    <= '0;
      cap_y    <= '0;
      x_q      <= '0;
      y_q      <= '0;
      z_q      <= '0;
      origin_q <= 1'b0;
      res_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            cap_x <= in_x;
            cap_y <= in_y;
            st_q  <= ST_PREP;
          end
        end
        ST_PREP: begin
          x_q      <= fold_x;
          y_q      <= fold_y;
          z_q      <= fold_z;
          origin_q <= fold_origin;
          iter_q   <= '0;
          st_q     <= ST_RUN;
        end
        ST_RUN: begin
          x_q    <= rot_x;
          y_q    <= rot_y;
          z_q    <= rot_z;
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST_STEP) st_q <= ST_FINISH;
        end
        default: begin
          res_q <= origin_q ? '0 : z_q;
          vld_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready       = (st_q == ST_IDLE);
  assign out_valid      = vld_q;
  assign out_angle_wide = res_q;
  assign out_angle      = res_q[ANG_W-2 -: OUT_W];
endmodule

// File: rtl/pi_atan2_chk.sv
module pi_atan2_chk #(
  parameter int ANG_W   = 18,
  parameter int LATENCY = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [ANG_W-1:0] out_angle_wide
);
  localparam int CW  = $clog2(LATENCY + 2) + 1;
  localparam int LIM = (1 << (ANG_W - 2)) + 32;

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n) since_q <= '0;
    else if (in_valid && in_ready) since_q <= CW'(1);
    else if (since_q != '0 && since_q <= CW'(LATENCY)) since_q <= since_q + 1'b1;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (since_q == CW'(LATENCY + 1))); // R3
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> in_ready); // R3
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_angle_wide)); // R9
  AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'($signed(out_angle_wide)) <= LIM && int'($signed(out_angle_wide)) >= -LIM)); // R4
endmodule

bind pi_atan2_unit pi_atan2_chk #(.ANG_W(ANG_W), .LATENCY(ITER + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_angle_wide(out_angle_wide)
);

// File: tb/pi_atan2_unit_tb.sv
`timescale 1ns/100ps
module pi_atan2_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_x = '0, in_y = '0;
  logic out_valid;
  logic [17:0] out_angle_wide;
  logic [15:0] out_angle;

  int checks = 0, failures = 0;
  int cyc = 0, ready_at = 0;
  bit acc_seen = 1'b0, have_result = 1'b0, done = 1'b0;
  logic [17:0] last_wide = '0;
  int q_due[$], q_x[$], q_y[$];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pi_atan2_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
    .out_angle_wide(out_angle_wide), .out_angle(out_angle)
  );

  function automatic int exp_wide(int x, int y);
    real r;
    if (x == 0 && y == 0) return 0;
    r = $atan2(real'(y), real'(x)) / 3.14159265358979 * 65536.0;
    return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
  endfunction

  function automatic int circ(int d, int m);
    int v = d % m;
    if (v > m / 2) v -= m;
    if (v < -m / 2) v += m;
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // reference model, sampled shortly before each rising edge
  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      bit exp_v;
      exp_v = (q_due.size() > 0) && (q_due[0] == cyc);
      if (exp_v || out_valid) check(out_valid == exp_v, "R3 out_valid timing", out_valid, exp_v);
      check(in_ready == (cyc >= ready_at), "R2 in_ready", in_ready, cyc >= ready_at);
      if (exp_v) begin
        int x, y, e, got, gn, en;
        x = q_x.pop_front(); y = q_y.pop_front(); void'(q_due.pop_front());
        e = exp_wide(x, y);
        got = int'($signed(out_angle_wide));
        gn = int'(out_angle);
        en = (e >>> 1) & 16'hFFFF;
        if (x == 0 && y == 0) begin
          check(got == 0 && gn == 0, "R6 origin", got, 0);
        end else if (x < 0 && y == 0) begin
          check(circ(gn - 32768, 65536) <= 8, "R7 half turn", gn, 32768);
        end else if ((x == 0 || y == 0)) begin
          check(circ(got - e, 131072) <= 16, "R8 axis", got, e);
        end else begin
          check(circ(got - e, 131072) <= 16, "R4 angle", got, e);
        end
        check(gn == int'(out_angle_wide[16:1]), "R5 narrow bits", gn, int'(out_angle_wide[16:1]));
        check(circ(gn - en, 65536) <= 9, "R5 narrow value", gn, en);
        last_wide = out_angle_wide;
        have_result = 1'b1;
      end else if (have_result) begin
        if (out_angle_wide != last_wide) check(1'b0, "R9 hold", out_angle_wide, last_wide);
      end
      acc_seen = in_valid && in_ready;
      if (acc_seen) begin
        q_due.push_back(cyc + 19);
        q_x.push_back(int'($signed(in_x)));
        q_y.push_back(int'($signed(in_y)));
        ready_at = cyc + 19;
      end
    end
    cyc++;
  end

  task automatic send(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk); #0.5;
    in_valid = 1'b1; in_x = x; in_y = y;
    do @(posedge clk); while (!acc_seen);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #0.5;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_angle_wide == '0 && out_angle == '0, "R1 angles", out_angle_wide, 0);

    send(16'h0000, 16'h0000); idle(22);          // R6
    send(16'h4000, 16'h0000); idle(22);          // R8 +x
    send(16'h0000, 16'h4000); idle(22);          // R8 +y
    send(16'h0000, 16'hC000); idle(22);          // R8 -y
    send(16'hC000, 16'h0000); idle(22);          // R7
    send(16'h8000, 16'h0000); idle(22);          // R7 at -1.0
    send(16'h7FFF, 16'h7FFF);                    // R4 corners back to back
    send(16'h8000, 16'h8000);
    send(16'h8000, 16'h7FFF);
    send(16'h7FFF, 16'h8000);
    idle(3);
    // R2: decoys held while busy must be ignored
    send(16'h5000, 16'h2000);
    @(negedge clk); #0.5;
    in_valid = 1'b1; in_x = 16'h9000; in_y = 16'h1234;
    repeat (10) @(posedge clk);
    idle(12);
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a, b;
      a = rnd16(); b = rnd16();
      if (i % 2 == 0) a = {a[15], 1'b1, a[13:0]} ^ (a[15] ? 16'h4000 : 16'h0000);
      else b = {b[15], 1'b1, b[13:0]} ^ (b[15] ? 16'h4000 : 16'h0000);
      send(a, b);
      if (i % 7 == 3) idle(25);
    end
    idle(30);
    check(q_due.size() == 0, "R3 all results seen", q_due.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule